// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block models a single storage-and-output cell of a sum-of-products programmable logic fabric. It receives one sum-of-products term, a bundle of candidate clocks and a set of static configuration inputs. It returns a pin-side value with its drive enable, and a feedback bit that goes back to the logic array. The configuration picks one operating mode:

- a pure combinational path,
- a transparent latch,
- an edge-triggered register that can act as a D-type or a T-type element,
- one of two buried input-capture modes. In these modes the pin is released, and the cell registers or latches the external pin value before handing it to the array.

The same selected clock line triggers the register and gates the latch. Polarity inversion applies to the value that leaves the cell in the output modes. The configuration is wired once and must stay constant after reset. A synchronous active-high reset clears the register on an edge of the selected clock. While reset is high, the latch is held at 0.

Mode codes on `cfg_mode` are:

| Code | Mode | Behaviour |
|------|------|-----------|
| 0 | COMB | combinational |
| 1 | LATCH | transparent latch |
| 2 | REG | register |
| 3 | IN_REG | buried input register |
| 4 | IN_LATCH | buried input latch |
| 5–7 | (unused) | behave as COMB |

Top module: `mcell_top`

## Requirements
- R1: While `rst` is 1, a rising edge of the selected clock clears the register, and the latch is held at 0. After reset is released, the register and latch modes present `cfg_inv` on `pin_out`, and the buried modes present 0 on `fb`.
- R2: With `cfg_mode`=0 (COMB), `pin_out` equals `sop` XOR `cfg_inv` with no clock involvement.
- R3: With `cfg_mode`=1 (LATCH), the latch follows `sop` while the selected clock is high, and holds its value while that clock is low. `pin_out` is the latch value XOR `cfg_inv`.
- R4: With `cfg_mode`=2 (REG) and `cfg_tff`=0, the register loads `sop` on each rising edge of the selected clock.
- R5: With `cfg_mode`=2 (REG) and `cfg_tff`=1, the register inverts its state on a rising edge when `sop` is 1, and keeps its state when `sop` is 0.
- R6: In the output modes (codes 0, 1, 2 and 5–7), `cfg_inv`=1 inverts the cell value on `pin_out`, and on `fb` when `fb` carries the cell value.
- R7: Only edges and levels of `clks[cfg_clk_sel]` affect the register and the latch. Pulses on the other clocks change nothing.
- R8: In the output modes, `pin_oe` equals `cfg_oe`. When `cfg_oe` is 1, `fb` equals `pin_out`. When `cfg_oe` is 0, `fb` equals `pin_in`.
- R9: With `cfg_mode`=3 (IN_REG), `pin_oe` and `pin_out` are 0. The register loads `pin_in` on each rising edge, as a D-type element whatever `cfg_tff` says, and `fb` shows the register without inversion.
- R10: With `cfg_mode`=4 (IN_LATCH), `pin_oe` and `pin_out` are 0, and `fb` shows a latch that follows `pin_in` while the selected clock is high and holds while it is low.
- R11: The unused mode codes 5, 6 and 7 behave exactly like code 0 (COMB).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clks | input | NUM_CLK | Candidate clock lines; one drives register edge and latch gate |
| rst | input | 1 | Synchronous active-high reset for the storage element |
| cfg_mode | input | 3 | Operating mode code (see R2, R3, R4, R9, R10, R11) |
| cfg_clk_sel | input | SEL_W | Index of the clock line to use |
| cfg_tff | input | 1 | 1 = toggle register, 0 = data register (REG mode) |
| cfg_inv | input | 1 | 1 = invert the cell value towards pin and feedback |
| cfg_oe | input | 1 | Pin drive enable in the output modes |
| sop | input | 1 | Sum-of-products term from the logic array |
| pin_in | input | 1 | Value currently present on the external pin |
| pin_out | output | 1 | Value for the pin driver |
| pin_oe | output | 1 | Pin driver enable; 0 means tri-stated |
| fb | output | 1 | Feedback bit returned to the logic array |

## Verification
The bench builds the cell with the default of four clock lines, so `cfg_clk_sel` takes every value from 0 to 3. With that build, every combination of mode code (all eight, including the unused ones), polarity, register type, drive enable and clock index can be swept. Each sweep step applies random `sop` and `pin_in` values before a clock rise, while the clock is high and after it falls. This exercises latch transparency and hold as well as register capture. Pulses on the non-selected lines show that they are ignored. A directed toggle sequence confirms the T-type alternation with literal expected values.

// File: rtl/mcell_pkg.sv
`timescale 1ns/1ps
package mcell_pkg;

    typedef enum logic [2:0] {
        CELL_COMB     = 3'd0,
        CELL_LATCH    = 3'd1,
        CELL_REG      = 3'd2,
        CELL_IN_REG   = 3'd3,
        CELL_IN_LATCH = 3'd4
    } cell_mode_e;

    function automatic logic mode_is_buried(input cell_mode_e m);
        return (m == CELL_IN_REG) || (m == CELL_IN_LATCH);
    endfunction

endpackage

// File: rtl/mcell_clk_pick.sv
`timescale 1ns/1ps
module mcell_clk_pick #(
    parameter int unsigned NUM_CLK = 4,
    localparam int unsigned SEL_W  = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
    input  logic [NUM_CLK-1:0] clks,
    input  logic [SEL_W-1:0]   sel,
    output logic               gate
);

    logic [NUM_CLK-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CLK; gi++) begin : g_line
            assign hit[gi] = clks[gi] & (sel == SEL_W'(gi));
        end
    endgenerate

    assign gate = |hit;

endmodule

// File: rtl/mcell_store.sv
`timescale 1ns/1ps
module mcell_store
    import mcell_pkg::*;
(
    input  logic       gate,
    input  logic       rst,
    input  cell_mode_e mode,
    input  logic       tff,
    input  logic       sop,
    input  logic       pin_in,
    output logic       q_ff,
    output logic       q_lat
);

    logic ff_d;
    logic lat_d;

    always_comb begin
        if (mode == CELL_IN_REG) begin
            ff_d = pin_in;
        end else if (tff) begin
            ff_d = q_ff ^ sop;
        end else begin
            ff_d = sop;
        end
        lat_d = (mode == CELL_IN_LATCH) ? pin_in : sop;
    end

    always_ff @(posedge gate) begin
        if (rst) begin
            q_ff <= 1'b0;
        end else begin
            q_ff <= ff_d;
        end
    end

    always_latch begin
        if (rst) begin
            q_lat <= 1'b0;
        end else if (gate) begin
            q_lat <= lat_d;
        end
    end

    // R4
    d_capture_chk: assert property (@(posedge gate) disable iff (rst)
        (mode == CELL_REG && !tff) |=> (q_ff == $past(sop)));

    // R5
    t_toggle_chk: assert property (@(posedge gate) disable iff (rst)
        (mode == CELL_REG && tff) |=> (q_ff == ($past(q_ff) ^ $past(sop))));

    // R9
    in_capture_chk: assert property (@(posedge gate) disable iff (rst)
        (mode == CELL_IN_REG) |=> (q_ff == $past(pin_in)));

endmodule

// File: rtl/mcell_route.sv
`timescale 1ns/1ps
module mcell_route
    import mcell_pkg::*;
(
    input  logic       gate,
    input  logic       rst,
    input  cell_mode_e mode,
    input  logic       inv,
    input  logic       oe,
    input  logic       sop,
    input  logic       pin_in,
    input  logic       q_ff,
    input  logic       q_lat,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       fb
);

    logic core;
    logic shown;

    always_comb begin
        unique case (mode)
            CELL_LATCH: core = q_lat;
            CELL_REG:   core = q_ff;
            default:    core = sop;
        endcase
        shown = core ^ inv;
    end

    always_comb begin
        if (mode_is_buried(mode)) begin
            pin_out = 1'b0;
            pin_oe  = 1'b0;
            fb      = (mode == CELL_IN_REG) ? q_ff : q_lat;
        end else begin
            pin_out = shown;
            pin_oe  = oe;
            fb      = oe ? shown : pin_in;
        end
    end

    // R2
    comb_path_chk: assert property (@(posedge gate) disable iff (rst)
        (mode == CELL_COMB) |-> (pin_out == (sop ^ inv)));

    // R8
    fb_pin_chk: assert property (@(posedge gate) disable iff (rst)
        (!mode_is_buried(mode) && !oe) |-> (fb == pin_in));

    // R9
    buried_release_chk: assert property (@(posedge gate) disable iff (rst)
        mode_is_buried(mode) |-> (!pin_oe && !pin_out));

endmodule

// File: rtl/mcell_top.sv
`timescale 1ns/1ps
module mcell_top
    import mcell_pkg::*;
#(
    parameter int unsigned NUM_CLK = 4,
    localparam int unsigned SEL_W  = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
    input  logic [NUM_CLK-1:0] clks,
    input  logic               rst,
    input  logic [2:0]         cfg_mode,
    input  logic [SEL_W-1:0]   cfg_clk_sel,
    input  logic               cfg_tff,
    input  logic               cfg_inv,
    input  logic               cfg_oe,
    input  logic               sop,
    input  logic               pin_in,
    output logic               pin_out,
    output logic               pin_oe,
    output logic               fb
);

    cell_mode_e mode;
    logic       gate;
    logic       q_ff;
    logic       q_lat;

    assign mode = cell_mode_e'(cfg_mode);

    mcell_clk_pick #(.NUM_CLK(NUM_CLK)) u_pick (
        .clks (clks),
        .sel  (cfg_clk_sel),
        .gate (gate)
    );

    mcell_store u_store (
        .gate   (gate),
        .rst    (rst),
        .mode   (mode),
        .tff    (cfg_tff),
        .sop    (sop),
        .pin_in (pin_in),
        .q_ff   (q_ff),
        .q_lat  (q_lat)
    );

    mcell_route u_route (
        .gate    (gate),
        .rst     (rst),
        .mode    (mode),
        .inv     (cfg_inv),
        .oe      (cfg_oe),
        .sop     (sop),
        .pin_in  (pin_in),
        .q_ff    (q_ff),
        .q_lat   (q_lat),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .fb      (fb)
    );

endmodule

// File: tb/tb_mcell_top.sv
`timescale 1ns/1ps
module tb_mcell_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0] clks;
    logic       rst;
    logic [2:0] cfg_mode;
    logic [1:0] cfg_clk_sel;
    logic       cfg_tff, cfg_inv, cfg_oe, sop, pin_in;
    wire        pin_out, pin_oe, fb;

    int  checks = 0;
    int  errors = 0;
    int  cycles = 0;
    bit  done   = 1'b0;
    logic r_ff, r_lat;

    mcell_top #(.NUM_CLK(4)) dut (
        .clks(clks), .rst(rst), .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
        .cfg_tff(cfg_tff), .cfg_inv(cfg_inv), .cfg_oe(cfg_oe), .sop(sop),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
    );

    function automatic logic [2:0] expect_out();
        logic v, po;
        case (cfg_mode)
            3'd3: return {1'b0, 1'b0, r_ff};
            3'd4: return {1'b0, 1'b0, r_lat};
            3'd1: v = r_lat;
            3'd2: v = r_ff;
            default: v = sop;
        endcase
        po = v ^ cfg_inv;
        return {po, cfg_oe, cfg_oe ? po : pin_in};
    endfunction

    function automatic string mode_tag();
        case (cfg_mode)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return cfg_tff ? "R5" : "R4";
            3'd3: return "R9";
            3'd4: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag);
        logic [2:0] exp;
        exp = expect_out();
        checks++;
        if ({pin_out, pin_oe, fb} !== exp) begin
            errors++;
            $display("FAIL %s mode=%0d inv=%0d tff=%0d oe=%0d sel=%0d got {out,oe,fb}=%b exp %b",
                     tag, cfg_mode, cfg_inv, cfg_tff, cfg_oe, cfg_clk_sel,
                     {pin_out, pin_oe, fb}, exp);
        end
    endtask

    task automatic check_lit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b exp %b", tag, got, exp);
        end
    endtask

    task automatic settle();
        #1;
        if (rst) r_lat = 1'b0;
        else if (clks[cfg_clk_sel]) r_lat = (cfg_mode == 3'd4) ? pin_in : sop;
        #1;
    endtask

    task automatic rise();
        logic nxt;
        if (rst) nxt = 1'b0;
        else if (cfg_mode == 3'd3) nxt = pin_in;
        else if (cfg_tff) nxt = r_ff ^ sop;
        else nxt = sop;
        clks[cfg_clk_sel] = 1'b1;
        r_ff = nxt;
        settle();
    endtask

    task automatic fall();
        clks[cfg_clk_sel] = 1'b0;
        settle();
    endtask

    task automatic new_inputs();
        sop    = 1'($urandom % 2);
        pin_in = 1'($urandom % 2);
        settle();
    endtask

    task automatic start_config(input logic [2:0] m, input logic [1:0] s,
                                input logic t, input logic i, input logic o);
        clks = '0;
        #1;
        cfg_mode = m; cfg_clk_sel = s; cfg_tff = t; cfg_inv = i; cfg_oe = o;
        rst = 1'b1;
        new_inputs();
        rise();
        fall();
        rst = 1'b0;
        settle();
        // R1: state cleared after reset
        check("R1");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        clks = '0; rst = 1'b1; cfg_mode = '0; cfg_clk_sel = '0;
        cfg_tff = 1'b0; cfg_inv = 1'b0; cfg_oe = 1'b1; sop = 1'b0; pin_in = 1'b0;
        r_ff = 1'b0; r_lat = 1'b0;

        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int cfg = 0; cfg < 8; cfg++) begin
                    start_config(3'(m), 2'(s), cfg[0], cfg[1], cfg[2]);
                    for (int k = 0; k < 10; k++) begin
                        string tg;
                        tg = $sformatf("%s/R6/R8", mode_tag());
                        new_inputs();
                        check(tg);
                        rise();
                        check(tg);
                        new_inputs();
                        check(tg);
                        fall();
                        check(tg);
                        new_inputs();
                        check(tg);
                        if (($urandom % 3) == 0) begin
                            int other;
                            other = (s + 1 + int'($urandom % 3)) % 4;
                            new_inputs();
                            clks[other] = 1'b1;
                            settle();
                            // R7: unselected clock must not disturb state
                            check("R7");
                            clks[other] = 1'b0;
                            settle();
                            check("R7");
                        end
                    end
                end
            end
        end

        // R5 directed: toggle register alternates with sop held at 1
        start_config(3'd2, 2'd1, 1'b1, 1'b0, 1'b1);
        sop = 1'b1; settle();
        rise(); fall();
        check_lit("R5 toggle1", pin_out, 1'b1);
        rise(); fall();
        check_lit("R5 toggle2", pin_out, 1'b0);
        sop = 1'b0; settle();
        rise(); fall();
        check_lit("R5 hold", pin_out, 1'b0);

        // R3 directed: latch holds while gate low
        start_config(3'd1, 2'd2, 1'b0, 1'b0, 1'b1);
        sop = 1'b1; settle();
        rise();
        check_lit("R3 transparent", pin_out, 1'b1);
        fall();
        sop = 1'b0; settle();
        check_lit("R3 hold", pin_out, 1'b1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule